// File: doc/BRIEF.md
# Presettable Synchronous Up Counter with Dual Count Enables

This block is a binary up counter in which every state bit is updated on the same rising clock edge. No bit is clocked by another bit's output. Four modes are selected from the control inputs in a fixed priority:

- a synchronous clear;
- a synchronous parallel preset from a data bus;
- counting;
- holding.

Counting requires two separate enables to be high together. The first is a cascade enable, and it also gates the terminal-count output. The second is a local enable, and it only affects this stage.

To build a wider counter, chain stages. Feed the terminal-count output of one stage into the cascade enable of the next. Drive every local enable from a common signal. The contents are undefined after power-up until a clear or a preset is applied, so the block has no reset port.

Top module: `preset_up_counter`

## Requirements
- R1: When `clr` is high at a rising edge of `clk`, `count` becomes 0 after that edge, whatever the enables are.
- R2: When `load` is high and `clr` is low at a rising edge, `count` takes the value on `preset` after that edge.
- R3: When `clr` and `load` are both high at an edge, the clear wins and `count` becomes 0.
- R4: When `clr` and `load` are low and `en_casc` and `en_local` are both high at an edge, `count` increases by exactly one. The lowest bit toggles, and bit i toggles only when all bits below it are 1.
- R5: When `clr` and `load` are low and at least one enable is low at an edge, `count` keeps its value.
- R6: `term` is high exactly when `count` is all ones and `en_casc` is high. It follows these inputs without waiting for a clock, and `en_local` has no effect on it.
- R7: An enabled count edge taken from the all-ones value gives 0 directly.
- R8: Clear and preset do not depend on the enables. A preset applied while both enables are low still loads `preset`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clr | input | 1 | Synchronous clear, active high, highest priority |
| load | input | 1 | Synchronous parallel preset, active high |
| preset | input | WIDTH | Value loaded by a preset |
| en_casc | input | 1 | Cascade count enable; also gates `term` |
| en_local | input | 1 | Local count enable |
| count | output | WIDTH | Current counter value |
| term | output | 1 | Terminal count, for cascading |

## Verification
- **Registered results (`count`):** the outcome of clear, preset, count and hold shows on `count` one rising edge after the controls are sampled. The bench applies inputs on the falling edge. Its model updates the expected value on the same rising edge as the design, and `count` is compared on the following falling edge.
- **Combinational result (`term`):** `term` is due in the same cycle as its inputs. It is checked a quarter period after each falling edge, once the new enables have settled. The expected value comes from the model's count and the enable just driven.
- **Before the first clear or preset:** no check is made, because the contents are undefined until then.

// File: rtl/preset_up_counter.sv
module preset_up_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] preset,
  input  logic             en_casc,
  input  logic             en_local,
  output logic [WIDTH-1:0] count,
  output logic             term
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] flip;
  logic [WIDTH-1:0] q;

  assign chain[0] = en_casc & en_local;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign flip[i]     = chain[i];
    assign chain[i+1]  = chain[i] & q[i];

    always_ff @(posedge clk) begin
      if (clr)       q[i] <= 1'b0;
      else if (load) q[i] <= preset[i];
      else if (flip[i]) q[i] <= ~q[i];
    end
  end

  assign count = q;
  assign term  = (&q) & en_casc;

  logic primed = 1'b0;
  always_ff @(posedge clk) if (clr || load) primed <= 1'b1;

  // R1
  clear_zero_chk: assert property (@(posedge clk) clr |=> count == '0);

  // R2
  preset_take_chk: assert property (@(posedge clk) (load && !clr) |=> count == $past(preset));

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!primed)
    (!clr && !load && en_casc && en_local && count != ALL_ONES) |=> count == $past(count) + 1'b1);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!primed)
    (!clr && !load && !(en_casc && en_local)) |=> $stable(count));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!primed)
    (!clr && !load && en_casc && en_local && count == ALL_ONES) |=> count == '0);

endmodule

// File: tb/preset_up_counter_tb.sv
module preset_up_counter_tb;
  logic       clk = 1'b0;
  logic       clr = 1'b1, load = 1'b0, en_casc = 1'b0, en_local = 1'b0;
  logic [3:0] preset = 4'd0;
  logic [3:0] count;
  logic       term;

  int checks = 0, fails = 0;
  int ref_cnt = 0;
  bit known = 0;
  string tag = "R1";

  preset_up_counter #(.WIDTH(4)) u_dut (
    .clk(clk), .clr(clr), .load(load), .preset(preset),
    .en_casc(en_casc), .en_local(en_local), .count(count), .term(term));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (clr) begin
      ref_cnt <= 0; tag <= load ? "R3" : "R1";
    end else if (load) begin
      ref_cnt <= int'(preset); tag <= (en_casc && en_local) ? "R2" : "R8";
    end else if (en_casc && en_local) begin
      ref_cnt <= (ref_cnt + 1) % 16; tag <= (ref_cnt == 15) ? "R7" : "R4";
    end else begin
      tag <= "R5";
    end
    if (clr || load) known <= 1'b1;
  end

  always @(negedge clk) begin
    if (known) begin
      checks++;
      if (int'(count) != ref_cnt) begin
        fails++;
        $display("FAIL %s count actual=%0d expected=%0d", tag, count, ref_cnt);
      end
      #5;
      checks++;
      if (term !== (ref_cnt == 15 && en_casc)) begin
        fails++;
        $display("FAIL R6 term actual=%0b expected=%0b", term, (ref_cnt == 15 && en_casc));
      end
    end
  end

  task automatic step(input logic c, input logic l, input logic [3:0] d,
                      input logic t, input logic p);
    @(negedge clk);
    clr = c; load = l; preset = d; en_casc = t; en_local = p;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state via clear, with enables high
    step(1, 0, 4'd9, 1, 1);
    // R8 preset with enables low
    step(0, 1, 4'd5, 0, 0);
    // R4 counting
    repeat (4) step(0, 0, 4'd0, 1, 1);
    // R5 hold with one enable low each way
    repeat (2) step(0, 0, 4'd0, 1, 0);
    repeat (2) step(0, 0, 4'd0, 0, 1);
    // R6 term at 15 with local enable low, then cascade low
    step(0, 1, 4'd15, 0, 0);
    step(0, 0, 4'd0, 1, 0);
    step(0, 0, 4'd0, 0, 1);
    // R7 wrap
    step(0, 1, 4'd14, 1, 1);
    repeat (4) step(0, 0, 4'd0, 1, 1);
    // R3 clear beats preset
    step(0, 1, 4'd11, 0, 0);
    step(1, 1, 4'd7, 1, 1);
    // R2 preset while enabled
    step(0, 1, 4'd10, 1, 1);
    // mixed stimulus
    for (int k = 0; k < 600; k++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 4, (r >= 4 && r < 12) || r == 0, 4'($urandom_range(0, 15)),
           $urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0);
    end
    step(0, 0, 4'd0, 0, 0);
    @(negedge clk);
    #8;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule